// File: doc/BRIEF.md
# Serial Frequency Word Loader

This block collects a frequency control word that arrives one bit at a time over two wires, a data line and a sync line, both sampled on the rising edge of one clock. A one-cycle sync pulse marks the start of a word. The data bit that starts it arrives in the cycle that follows the pulse. Bits arrive most significant first. A 2-bit selector chooses how many bits the word carries: 8, 16, 24 or 32. The loader counts down from that length. When the last bit has been taken, the word goes into a 32-bit holding register, aligned to the top, and every bit below the received ones is cleared.

A single-cycle valid strobe goes out together with each new holding value. Other logic in the same clock domain, such as an oscillator phase accumulator, can use it to pick up the word. The sync line must never stay high for two cycles in a row. A sync that arrives while a word is still being collected discards that word and starts a new one. A sync that arrives together with the final bit of a word lets that word finish and begins the next word with no idle cycle.

Top module: `serial_fword_loader`

## Requirements
- R1: While reset is asserted, and after it is released, the holding output is zero and the valid strobe is low until the first complete word.
- R2: The selector codes 00, 01, 10 and 11 give word lengths of 8, 16, 24 and 32 bits. The first data bit is sampled one clock after the sync pulse, and bits fill the word from the MSB down.
- R3: A word shorter than 32 bits lands in the top bits of the holding register, and all lower holding bits are zero.
- R4: The valid strobe is high for exactly one cycle, in the cycle right after the clock edge that samples the word's final bit, and the holding output shows the new word in that same cycle.
- R5: Between transfers the holding output keeps its value. Activity on the data line with no word in progress has no effect on it.
- R6: A sync pulse before the final bit of a word in progress drops that word without a transfer, and a new count starts from the currently selected length.
- R7: A sync pulse in the same cycle as a word's final bit completes that word and starts the next one, so words can follow each other with no gap.
- R8: The length is captured when sync is sampled. Changes to the selector while a word is in progress do not alter that word's length or its alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_len_sel | input | 2 | Word length selector (00=8, 01=16, 10=24, 11=32 bits) |
| ser_sync | input | 1 | One-cycle start pulse, one cycle before the first data bit |
| ser_data | input | 1 | Serial data bit, MSB first |
| word_o | output | 32 | Holding register, left-aligned word with zeroed low bits |
| word_vld_o | output | 1 | One-cycle strobe for each new holding value |

## Verification
The sensitive coincidence is a sync pulse landing in the cycle that carries a word's final bit. The transfer of the old word and the start of the new one then happen on the same edge, and the same pulse one cycle earlier would abort the word instead. The bench provokes both cases directly, with back-to-back 8-bit words whose next sync overlaps the last bit and with a sync placed a few bits into a word. It also places sync pulses at random across a long run with random lengths. A bench model that follows the requirements predicts the strobe and holding value in every cycle. This makes it possible to tell a lost transfer, a spurious one, or an off-by-one abort boundary apart from a correct result.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  // Selector code to word length: length is one quarter of the holding
  // register width per step, code 0 giving the shortest word.
  function automatic int unsigned sel_bits(input logic [1:0] sel,
                                           input int unsigned hold_w);
    return (32'(sel) + 32'd1) * (hold_w / 32'd4);
  endfunction

endpackage

// File: rtl/sfl_bitcount.sv
module sfl_bitcount
  import sfl_pkg::*;
#(
  parameter int unsigned HOLD_W = 32,
  parameter int unsigned CNT_W  = $clog2(HOLD_W + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_i,
  input  logic [1:0] sel_i,
  output logic       busy_o,
  output logic       last_o,
  output logic [1:0] sel_q_o
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [1:0]       sel_q, sel_n;

  always_comb begin
    cnt_n = cnt_q;
    sel_n = sel_q;
    if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
    if (sync_i) begin
      cnt_n = CNT_W'(sel_bits(sel_i, HOLD_W));
      sel_n = sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      sel_q <= sel_n;
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign last_o  = (cnt_q == CNT_W'(1));
  assign sel_q_o = sel_q;

  // R2: a sync loads the length chosen by the selector on that edge
  a_r2_load_len: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> cnt_q == CNT_W'(sel_bits($past(sel_i), HOLD_W)));

  // R2: one bit consumed per cycle while a word is in progress
  a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !sync_i) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R8: captured length is not touched by the selector mid-word
  a_r8_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !sync_i) |=> $stable(sel_q));

endmodule

// File: rtl/sfl_shreg.sv
module sfl_shreg #(
  parameter int unsigned HOLD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [HOLD_W-1:0] nxt_o
);

  logic [HOLD_W-1:0] sreg_q, sreg_n;

  always_comb begin
    sreg_n = sreg_q;
    if (en_i) sreg_n = {sreg_q[HOLD_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_n;
  end

  assign nxt_o = sreg_n;

  // R2: earlier bits move toward the MSB, the newest sits at bit 0
  a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (sreg_q[0] == $past(bit_i)) &&
             (sreg_q[HOLD_W-1:1] == $past(sreg_q[HOLD_W-2:0])));

endmodule

// File: rtl/sfl_hold.sv
module sfl_hold
  import sfl_pkg::*;
#(
  parameter int unsigned HOLD_W = 32,
  parameter int unsigned CNT_W  = $clog2(HOLD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [1:0]        sel_i,
  input  logic [HOLD_W-1:0] word_i,
  output logic [HOLD_W-1:0] hold_o,
  output logic              vld_o
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(HOLD_W);

  logic [CNT_W-1:0]  nbits;
  logic [HOLD_W-1:0] aligned;
  logic [HOLD_W-1:0] hold_q;
  logic              vld_q;

  always_comb begin
    nbits   = CNT_W'(sel_bits(sel_i, HOLD_W));
    aligned = word_i << (FULL - nbits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= ld_i;
      if (ld_i) hold_q <= aligned;
    end
  end

  assign hold_o = hold_q;
  assign vld_o  = vld_q;

  // R3: bits below the received word are clear after a transfer
  a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (hold_q & ({HOLD_W{1'b1}} >> sel_bits($past(sel_i), HOLD_W))) == '0);

  // R5: holding value only changes together with the strobe
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(hold_q));

  // R4: strobe never lasts two cycles
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

endmodule

// File: rtl/serial_fword_loader.sv
module serial_fword_loader #(
  parameter int unsigned HOLD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_len_sel,
  input  logic              ser_sync,
  input  logic              ser_data,
  output logic [HOLD_W-1:0] word_o,
  output logic              word_vld_o
);

  localparam int unsigned CNT_W = $clog2(HOLD_W + 1);

  logic              busy, last;
  logic [1:0]        sel_q;
  logic [HOLD_W-1:0] shift_nxt;

  sfl_bitcount #(.HOLD_W(HOLD_W), .CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (ser_sync),
    .sel_i   (cfg_len_sel),
    .busy_o  (busy),
    .last_o  (last),
    .sel_q_o (sel_q)
  );

  sfl_shreg #(.HOLD_W(HOLD_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (busy),
    .bit_i (ser_data),
    .nxt_o (shift_nxt)
  );

  sfl_hold #(.HOLD_W(HOLD_W), .CNT_W(CNT_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_i   (last),
    .sel_i  (sel_q),
    .word_i (shift_nxt),
    .hold_o (word_o),
    .vld_o  (word_vld_o)
  );

  // R6: a sync before the final bit cancels the transfer
  a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && ser_sync) |=> !word_vld_o);

  // R7: a sync on the final bit still delivers the word
  a_r7_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (last && ser_sync) |=> word_vld_o);

endmodule

// File: tb/tb_serial_fword_loader.sv
module tb_serial_fword_loader;

  logic        clk;
  logic        rst_n;
  logic [1:0]  cfg_len_sel;
  logic        ser_sync;
  logic        ser_data;
  logic [31:0] word_o;
  logic        word_vld_o;

  serial_fword_loader dut (
    .clk(clk), .rst_n(rst_n), .cfg_len_sel(cfg_len_sel),
    .ser_sync(ser_sync), .ser_data(ser_data),
    .word_o(word_o), .word_vld_o(word_vld_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  string       tag;

  // bench model state, built from the requirements
  int unsigned rem = 0;
  int unsigned nw  = 0;
  logic [31:0] acc = '0;
  logic [31:0] exp_word = '0;
  logic        exp_vld  = 1'b0;
  logic        prev_sync = 1'b0;

  function automatic int unsigned len_of(input logic [1:0] c);
    return (32'(c) + 1) * 8;   // R2 encoding
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic d, input logic [1:0] c);
    @(negedge clk);
    check(word_vld_o == exp_vld, tag, "strobe", 32'(word_vld_o), 32'(exp_vld));
    check(word_o == exp_word, tag, "holding", word_o, exp_word);
    exp_vld = 1'b0;
    if (rem > 0) begin
      acc = {acc[30:0], d};
      rem--;
      if (rem == 0) begin
        exp_vld  = 1'b1;
        exp_word = acc << (32 - nw);
      end
    end
    if (s) begin
      rem = len_of(c);
      nw  = rem;
    end
    ser_sync    = s;
    ser_data    = d;
    cfg_len_sel = c;
    prev_sync   = s;
  endtask

  // sends a word; lead controls the opening sync, tail puts a sync on the last bit
  task automatic send(input logic [1:0] c, input logic [31:0] v,
                      input bit lead, input bit tail);
    int unsigned n = len_of(c);
    if (lead) step(1'b1, 1'b0, c);
    for (int i = 0; i < int'(n); i++)
      step((i == int'(n) - 1) ? tail : 1'b0, v[n-1-i], c);
  endtask

  initial begin
    rst_n = 1'b0; ser_sync = 1'b0; ser_data = 1'b0; cfg_len_sel = 2'b00;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(word_o == '0, "R1", "reset holding", word_o, '0);
    check(word_vld_o == 1'b0, "R1", "reset strobe", 32'(word_vld_o), '0);
    rst_n = 1'b1;
    tag = "R1";
    step(1'b0, 1'b1, 2'b11);
    step(1'b0, 1'b1, 2'b11);

    // R2 / R3: every length, known pattern
    for (int c = 0; c < 4; c++) begin
      tag = (c == 3) ? "R2" : "R3";
      send(2'(c), 32'h96A5_C31E >> (24 - 8 * ((c < 3) ? c : 3)), 1'b1, 1'b0);
      tag = "R4";
      step(1'b0, 1'b1, 2'(c));
      step(1'b0, 1'b0, 2'(c));
    end

    // R5: idle data line ignored
    tag = "R5";
    for (int i = 0; i < 30; i++) step(1'b0, 1'($urandom), 2'($urandom));

    // R6: abort after 5 bits, then a full 16-bit word
    tag = "R6";
    step(1'b1, 1'b0, 2'b01);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 2'b01);
    send(2'b01, 32'h0000_3C5A, 1'b1, 1'b0);
    step(1'b0, 1'b0, 2'b01);
    // abort on the next-to-last bit
    step(1'b1, 1'b0, 2'b00);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 2'b00);
    send(2'b00, 32'h0000_0081, 1'b1, 1'b0);

    // R7: back-to-back words sharing sync and final bit
    tag = "R7";
    send(2'b00, 32'h0000_00C3, 1'b1, 1'b1);
    send(2'b00, 32'h0000_0055, 1'b0, 1'b1);
    send(2'b01, 32'h0000_F00F, 1'b0, 1'b0);
    step(1'b0, 1'b0, 2'b00);

    // R8: selector moves mid-word
    tag = "R8";
    step(1'b1, 1'b0, 2'b00);
    for (int i = 0; i < 8; i++) step(1'b0, 1'(i[0]), 2'b11);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 2'b10);
    step(1'b1, 1'b0, 2'b11);
    for (int i = 0; i < 32; i++) step(1'b0, 1'($urandom), 2'b00);
    step(1'b0, 1'b0, 2'b00);

    // random run, sync never on two adjacent cycles
    tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      logic s;
      s = (($urandom % 14) == 0) && !prev_sync;
      step(s, 1'($urandom), 2'($urandom));
    end
    for (int i = 0; i < 40; i++) step(1'b0, 1'($urandom), 2'($urandom));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule